// File: doc/BRIEF.md
# Address Security Attribution Checker

This block tags every transaction address with fixed security attributes. The upper four address bits select one of sixteen regions, and the block reports that region number. It also reports whether the region is non-secure. A separate flag marks an address that falls in one of two hard system windows, which are exempt from attribution. Each lookup is a pure function of the address and a small configuration register, so a requester can use the result in the same cycle it presents the address.

Two secure regions can each be opened as non-secure-callable entry windows. Software does this by writing a two-bit configuration register through a plain write-enable and data port. Reset clears the register, so no region is callable until software sets a bit. A write takes effect for every lookup that follows the clock edge that captured it.

Top module: `addr_attr_unit`

## Requirements
- R1: `region_o` equals `addr_i[31:28]` for every address.
- R2: `nonsec_o` is 1 exactly when `addr_i[28]` is 0, and 0 when `addr_i[28]` is 1.
- R3: For region 1, `callable_o` equals configuration bit 0.
- R4: For region 3, `callable_o` equals configuration bit 1. For every region other than 1 and 3, `callable_o` is 0.
- R5: `exempt_o` is 1 exactly when `(addr_i & 32'hEFF0_0000) == 32'hE000_0000`. These are the ranges 0xE000_0000..0xE00F_FFFF and 0xF000_0000..0xF00F_FFFF.
- R6: After reset the configuration register reads 0, and no region is callable.
- R7: A rising clock edge with `cfg_we_i` high loads `cfg_wdata_i[1:0]`. Without a write, the register holds its value. `cfg_rdata_o[31:2]` always reads 0, and upper write data bits are discarded.
- R8: `callable_o` is never 1 while `nonsec_o` is 1.
- R9: All four attribute outputs follow `addr_i` and the current register value combinationally, with no clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data; only bits [1:0] are used |
| cfg_rdata_o | output | 32 | Current configuration value, zero-extended |
| addr_i | input | 32 | Transaction address to attribute |
| region_o | output | 4 | Region number, taken from the top address nibble |
| nonsec_o | output | 1 | Region is non-secure |
| callable_o | output | 1 | Region is open as a non-secure-callable window |
| exempt_o | output | 1 | Address lies in an exempt system window |

## Verification
The attribute outputs have no latency. The bench drives an address at the falling edge and compares all four flags two nanoseconds after the next rising edge, while the address is still held. A configuration write is captured at the rising edge that follows the falling edge where `cfg_we_i` is raised. Lookups that use the new value are therefore queued only from the next falling edge onward, and the readback value is compared in that same later slot. The scoreboard pops exactly one expected item per clock, so each comparison lands in the cycle its stimulus was driven.

// File: rtl/addr_attr_pkg.sv
package addr_attr_pkg;
  localparam int unsigned REGION_W = 4;

  typedef struct packed {
    logic [REGION_W-1:0] region;
    logic                nonsec;
    logic                callable;
    logic                exempt;
  } attr_t;
endpackage

// File: rtl/addr_attr_cfg.sv
module addr_attr_cfg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i[CFG_W-1:0];
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{PAD_W{1'b0}}, cfg_q};

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[CFG_W-1:0] == $past(wdata_i[CFG_W-1:0]));
endmodule

// File: rtl/addr_attr_lookup.sv
module addr_attr_lookup
  import addr_attr_pkg::*;
#(
  parameter int unsigned              ADDR_W       = 32,
  parameter int unsigned              CFG_W        = 2,
  parameter logic [CFG_W*REGION_W-1:0] CALL_REGIONS = {4'd3, 4'd1},
  parameter logic [ADDR_W-1:0]        EXEMPT_MASK  = 32'hEFF0_0000,
  parameter logic [ADDR_W-1:0]        EXEMPT_MATCH = 32'hE000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output attr_t             attr_o
);
  localparam int unsigned SEC_BIT = ADDR_W - REGION_W;

  logic [REGION_W-1:0] region;
  logic [CFG_W-1:0]    win_hit;

  assign region = addr_i[ADDR_W-1 -: REGION_W];

  // one callable window per configuration bit
  for (genvar i = 0; i < CFG_W; i++) begin : g_win
    assign win_hit[i] = cfg_i[i] && (region == CALL_REGIONS[i*REGION_W +: REGION_W]);
  end

  assign attr_o.region   = region;
  assign attr_o.nonsec   = ~addr_i[SEC_BIT];
  assign attr_o.callable = |win_hit;
  assign attr_o.exempt   = (addr_i & EXEMPT_MASK) == EXEMPT_MATCH;
endmodule

// File: rtl/addr_attr_unit.sv
module addr_attr_unit
  import addr_attr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REGION_W-1:0] region_o,
  output logic              nonsec_o,
  output logic              callable_o,
  output logic              exempt_o
);
  logic [CFG_W-1:0] cfg;
  attr_t            attr;

  addr_attr_cfg #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  addr_attr_lookup #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_lookup (
    .addr_i (addr_i),
    .cfg_i  (cfg),
    .attr_o (attr)
  );

  assign region_o   = attr.region;
  assign nonsec_o   = attr.nonsec;
  assign callable_o = attr.callable;
  assign exempt_o   = attr.exempt;

  assert_call_secure_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    callable_o |-> !nonsec_o);
  assert_call_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    callable_o |-> ((region_o == 4'd1) && cfg_rdata_o[0]) ||
                   ((region_o == 4'd3) && cfg_rdata_o[1]));
  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[DATA_W-1:CFG_W] == '0);
  assert_exempt_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exempt_o |-> region_o[3:1] == 3'b111);
  assert_reset_clear_R6: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> cfg_rdata_o == '0);
endmodule

// File: tb/addr_attr_unit_tb.sv
module addr_attr_unit_tb;
  typedef struct {
    logic [31:0] addr;
    logic [31:0] rdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] addr = '0;
  logic [3:0]  region;
  logic        ns, nsc, ex;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;
  logic [1:0]  cfg_model = 2'b00;
  item_t       sb[$];

  always #4 clk = ~clk;

  addr_attr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .addr_i(addr), .region_o(region),
    .nonsec_o(ns), .callable_o(nsc), .exempt_o(ex)
  );

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h addr=%h", tag, act, exp, addr);
    end
  endtask

  // driver: drive at falling edge, queue expectation for the monitor
  task automatic look(logic [31:0] a, string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.addr = a; it.rdata = {30'b0, cfg_model}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    cfg_model = d[1:0];
    addr = 32'h1000_0000;
    begin
      item_t it;
      it.addr = addr; it.rdata = {30'b0, cfg_model}; it.tag = "R7";
      sb.push_back(it);
    end
  endtask

  // monitor: one item per cycle, 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() != 0) begin
        item_t it;
        logic [3:0] r;
        logic e_nsc;
        it = sb.pop_front();
        r = it.addr[31:28];
        e_nsc = (r == 4'd1 && it.rdata[0]) || (r == 4'd3 && it.rdata[1]);
        cmp("R1 R9 region", {28'b0, region}, {28'b0, r});
        cmp("R2 nonsec", {31'b0, ns}, {31'b0, ~it.addr[28]});
        cmp(r == 4'd1 ? "R3 callable" : (r == 4'd3 ? "R4 callable" : "R4 R8 callable"),
            {31'b0, nsc}, {31'b0, e_nsc});
        cmp("R5 exempt", {31'b0, ex},
            {31'b0, (it.addr & 32'hEFF0_0000) == 32'hE000_0000});
        cmp({it.tag, " rdata"}, rdata, it.rdata);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(32'h1000_0000, "R6");
    look(32'h3ABC_0000, "R6");
    // sweep every region under each configuration, incl. upper-bit garbage (R7)
    for (int c = 0; c < 4; c++) begin
      wr(32'hFFFF_FFFC | c);
      for (int r = 0; r < 16; r++) look({r[3:0], 28'h123_4567}, "R7");
    end
    wr(32'h0000_0001);
    foreach (lf[i]) ; // keep lf declared use-free
    look(32'h1000_0000, "R3"); look(32'h1FFF_FFFF, "R3");
    look(32'h3000_0000, "R4"); look(32'h0000_0000, "R2");
    look(32'hE000_0000, "R5"); look(32'hE00F_FFFF, "R5");
    look(32'hE010_0000, "R5"); look(32'hF00F_FFFF, "R5");
    look(32'hF010_0000, "R5"); look(32'hEFF0_0000, "R5");
    look(32'hDFFF_FFFF, "R5"); look(32'h6000_0000, "R8");
    wr(32'h0000_0002);
    look(32'h1000_0000, "R3"); look(32'h3FFF_FFFF, "R4");
    lf = 32'hACE1_2345;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (k % 15 == 0) wr(lf);
      look(lf, "R9");
    end
    // reset mid-run clears the register
    @(negedge clk); rst_n = 1'b0; cfg_model = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    look(32'h3000_0000, "R6");
    look(32'h1000_0000, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule